// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block is the front end for a set of external interrupt pins. It watches eight maskable request pins and one non-maskable pin. Each pin passes through a synchroniser. For each maskable line, a two-bit sense field chooses the event that counts: a low level, a falling edge, a rising edge, or either edge. When a line sees its chosen event, its bit in a request register is latched. The latched bit drives that line's interrupt output toward a downstream distributor, which handles masking and priority.

Software reads and writes 16-bit registers over a simple synchronous bus. A request bit is cleared only by writing zero to it. Writing one to a request bit leaves it unchanged. The non-maskable pin has three things of its own: an edge select, a request flag that is cleared the same way, and a live readback of its synchronised level. All of these sit in the control register.

Top module: `ext_irq_sense`

## Requirements
- R1: The sense register at byte offset 2 holds a two-bit field for each line n at bits [2n+1:2n]. The encodings are 0 = low level, 1 = falling edge, 2 = rising edge and 3 = both edges. The register reads back what was written and changes only when it is written.
- R2: In low-level mode (0), the request bit stays set while the synchronised pin is low, even after software writes zero to it.
- R3: In falling-edge mode (1), a high-to-low transition sets the request bit, and a low-to-high transition does not.
- R4: In rising-edge mode (2), a low-to-high transition sets the request bit, and a high-to-low transition does not.
- R5: In both-edges mode (3), a transition in either direction sets the request bit.
- R6: The request register sits at byte offset 4, with bit n for line n. Writing 0 to bit n clears it. Writing 1 to bit n leaves it unchanged. Nothing else clears it.
- R7: If an event arrives in the same cycle as a write of zero to the same request bit, the event wins and the bit stays set.
- R8: The control register is at byte offset 0. Bit 8 selects the non-maskable pin's active edge (0 = falling, 1 = rising). Bit 1 is that pin's request flag. The flag is set on the selected edge and cleared only by writing 0 to bit 1. The non-maskable output equals the flag.
- R9: Control register bit 15 reads the non-maskable pin's level after synchronisation (0 = low, 1 = high). This bit is read-only.
- R10: Unused register bits and unmapped offsets read as zero, and writes to them are ignored. After reset, every register bit reads zero except bit 15 of the control register, which shows the idle (high) pin level.
- R11: Interrupt output n equals request bit n.
- R12: A pin edge becomes visible in the request register after the third rising clock edge that follows the pin change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write happens at the clock edge |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ext_pin | input | 8 | External maskable request pins, asynchronous |
| nmi_pin | input | 1 | External non-maskable pin, asynchronous |
| line_irq | output | 8 | Interrupt output for each maskable line |
| nmi_irq | output | 1 | Non-maskable interrupt output |

## Verification
The bench targets the clear-versus-event collision. A design that lets the clear win would drop an interrupt that arrives in the same cycle as the acknowledge. It also checks that a low-level line re-asserts after a clear. A design that treated low level as a single event would lose a request that is still pending. Each edge mode is driven with the opposite transition to catch a swapped encoding, and the exact latency through the synchroniser is checked so that a missing or extra stage shows up. Writes of one to request and flag bits, and writes to reserved bits and unmapped offsets, must leave every readable bit unchanged. Random pin and bus traffic is then compared with a cycle model computed in the bench.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   // Per-line trigger sense encoding (field value is visible to software)
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_RISE = 2'd2,
      SENSE_BOTH = 2'd3
   } sense_e;
endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
   parameter int unsigned WIDTH   = 9,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stage_q [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("irq_sync_chain: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("irq_sync_chain: WIDTH must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM     = 9,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM-1:0]   lvl,
   input  logic [2*NUM-1:0] sense,
   output logic [NUM-1:0]   evt
);
   logic [NUM-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= {NUM{RST_VAL}};
      else        prev_q <= lvl;
   end

   for (genvar i = 0; i < NUM; i++) begin : g_line
      sense_e mode;
      logic   hit;
      assign mode = sense_e'(sense[2*i +: 2]);

      always_comb begin
         unique case (mode)
            SENSE_LOW:  hit = ~lvl[i];
            SENSE_FALL: hit = prev_q[i] & ~lvl[i];
            SENSE_RISE: hit = ~prev_q[i] & lvl[i];
            default:    hit = prev_q[i] ^ lvl[i];
         endcase
      end
      assign evt[i] = hit;

      AST_RISE_NEEDS_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == SENSE_RISE && evt[i]) |-> (lvl[i] && !$past(lvl[i]))); // R4
      AST_FALL_NEEDS_DOWNWARD: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == SENSE_FALL && evt[i]) |-> (!lvl[i] && $past(lvl[i]))); // R3
   end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
   parameter int unsigned NUM = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] evt,
   input  logic           clr_we,
   input  logic [NUM-1:0] wbits,
   output logic [NUM-1:0] req_q
);
   logic [NUM-1:0] keep_mask;

   // write-zero clears, write-one keeps; a fresh event overrides the clear
   assign keep_mask = clr_we ? wbits : {NUM{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= (req_q & keep_mask) | evt;
   end

   for (genvar b = 0; b < NUM; b++) begin : g_chk
      AST_CLEAR_ONLY_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(req_q[b]) |-> $past(clr_we && !wbits[b])); // R6
      AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         evt[b] |=> req_q[b]); // R7
   end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES    = 8,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 3,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic        PIN_IDLE     = 1'b1,
   parameter int unsigned CTRL_OFS     = 0,
   parameter int unsigned SENSE_OFS    = 2,
   parameter int unsigned REQ_OFS      = 4,
   parameter int unsigned NMI_LVL_BIT  = 15,
   parameter int unsigned NMI_EDGE_BIT = 8,
   parameter int unsigned NMI_FLAG_BIT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] ext_pin,
   input  logic                 nmi_pin,
   output logic [NUM_LINES-1:0] line_irq,
   output logic                 nmi_irq
);
   localparam int unsigned TOTAL   = NUM_LINES + 1;
   localparam int unsigned SENSE_W = 2 * NUM_LINES;

   initial begin
      assert (SENSE_W <= DATA_W) else $error("ext_irq_sense: sense fields exceed data width");
      assert (NMI_LVL_BIT < DATA_W && NMI_EDGE_BIT < DATA_W && NMI_FLAG_BIT < DATA_W)
         else $error("ext_irq_sense: control bit outside data width");
      assert (NMI_LVL_BIT != NMI_EDGE_BIT && NMI_LVL_BIT != NMI_FLAG_BIT && NMI_EDGE_BIT != NMI_FLAG_BIT)
         else $error("ext_irq_sense: control bits overlap");
      assert (CTRL_OFS != SENSE_OFS && CTRL_OFS != REQ_OFS && SENSE_OFS != REQ_OFS)
         else $error("ext_irq_sense: register offsets overlap");
      assert (REQ_OFS < (1 << ADDR_W) && SENSE_OFS < (1 << ADDR_W) && CTRL_OFS < (1 << ADDR_W))
         else $error("ext_irq_sense: offset beyond address width");
   end

   // register selects
   logic sel_ctrl, sel_sense, sel_req;
   assign sel_ctrl  = (bus_addr == ADDR_W'(CTRL_OFS));
   assign sel_sense = (bus_addr == ADDR_W'(SENSE_OFS));
   assign sel_req   = (bus_addr == ADDR_W'(REQ_OFS));

   // configuration state
   logic [SENSE_W-1:0] sense_q;
   logic               nmi_edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q    <= '0;
         nmi_edge_q <= 1'b0;
      end else begin
         if (bus_wr && sel_sense) sense_q    <= bus_wdata[SENSE_W-1:0];
         if (bus_wr && sel_ctrl)  nmi_edge_q <= bus_wdata[NMI_EDGE_BIT];
      end
   end

   // synchronise all pins together; top bit is the non-maskable pin
   logic [TOTAL-1:0] pin_sync;

   irq_sync_chain #(
      .WIDTH   (TOTAL),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({nmi_pin, ext_pin}),
      .dout  (pin_sync)
   );

   // non-maskable pin reuses the edge detector with a derived sense code
   logic [1:0]       nmi_sense;
   logic [TOTAL-1:0] evt_all;

   assign nmi_sense = nmi_edge_q ? SENSE_RISE : SENSE_FALL;

   irq_edge_detect #(
      .NUM     (TOTAL),
      .RST_VAL (PIN_IDLE)
   ) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_sync),
      .sense ({nmi_sense, sense_q}),
      .evt   (evt_all)
   );

   // request latches
   logic [NUM_LINES-1:0] req_q;
   logic [0:0]           nmi_flag_q;

   irq_req_bank #(.NUM(NUM_LINES)) u_line_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_all[NUM_LINES-1:0]),
      .clr_we (bus_wr && sel_req),
      .wbits  (bus_wdata[NUM_LINES-1:0]),
      .req_q  (req_q)
   );

   irq_req_bank #(.NUM(1)) u_nmi_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_all[TOTAL-1 -: 1]),
      .clr_we (bus_wr && sel_ctrl),
      .wbits  (bus_wdata[NMI_FLAG_BIT -: 1]),
      .req_q  (nmi_flag_q)
   );

   assign line_irq = req_q;
   assign nmi_irq  = nmi_flag_q[0];

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata[NMI_LVL_BIT]  = pin_sync[TOTAL-1];
         bus_rdata[NMI_EDGE_BIT] = nmi_edge_q;
         bus_rdata[NMI_FLAG_BIT] = nmi_flag_q[0];
      end else if (sel_sense) begin
         bus_rdata[SENSE_W-1:0] = sense_q;
      end else if (sel_req) begin
         bus_rdata[NUM_LINES-1:0] = req_q;
      end
   end

   AST_SENSE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel_sense) |=> $stable(sense_q)); // R1
   AST_NMI_EDGE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel_ctrl) |=> $stable(nmi_edge_q)); // R8
   AST_NMI_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_irq) |-> $past(bus_wr && sel_ctrl && !bus_wdata[NMI_FLAG_BIT])); // R8
endmodule

// File: tb/ext_irq_sense_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic [7:0]  ext_pin = 8'hFF;
   logic        nmi_pin = 1'b1;
   logic [7:0]  line_irq;
   logic        nmi_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_sense u_ext_irq_sense (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
      .nmi_pin(nmi_pin), .line_irq(line_irq), .nmi_irq(nmi_irq)
   );

   // ---------------- reference model, built from the requirements ----------
   logic [8:0]  m_s1, m_s2, m_pv;
   logic [15:0] m_sense;
   logic        m_edge, m_nmi;
   logic [7:0]  m_req, m_evt;
   logic        m_nevt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 9'h1FF; m_s2 = 9'h1FF; m_pv = 9'h1FF;
         m_sense = 16'd0; m_edge = 1'b0; m_nmi = 1'b0; m_req = 8'd0;
      end else begin
         for (int i = 0; i < 8; i++) begin
            case (m_sense[2*i +: 2])
               2'd0: m_evt[i] = !m_s2[i];                     // R2
               2'd1: m_evt[i] = m_pv[i] && !m_s2[i];          // R3
               2'd2: m_evt[i] = !m_pv[i] && m_s2[i];          // R4
               default: m_evt[i] = m_pv[i] != m_s2[i];        // R5
            endcase
         end
         m_nevt = m_edge ? (!m_pv[8] && m_s2[8]) : (m_pv[8] && !m_s2[8]);
         if (bus_wr && bus_addr == 3'd4) m_req = (m_req & bus_wdata[7:0]) | m_evt;
         else                            m_req = m_req | m_evt;
         if (bus_wr && bus_addr == 3'd0) begin
            m_nmi  = (m_nmi & bus_wdata[1]) | m_nevt;
            m_edge = bus_wdata[8];
         end else begin
            m_nmi = m_nmi | m_nevt;
         end
         if (bus_wr && bus_addr == 3'd2) m_sense = bus_wdata;
         m_pv = m_s2; m_s2 = m_s1; m_s1 = {nmi_pin, ext_pin};
      end
   end

   function automatic logic [15:0] model_rd(input logic [2:0] a);
      case (a)
         3'd0:    return {m_s2[8], 6'd0, m_edge, 6'd0, m_nmi, 1'b0};
         3'd2:    return m_sense;
         3'd4:    return {8'd0, m_req};
         default: return 16'd0;
      endcase
   endfunction

   // ---------------- helpers -----------------------------------------------
   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
      bus_addr = a;
      #0.5;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   // ---------------- watchdog ----------------------------------------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired (R12 progress) actual=hung expected=done");
         summary();
         $finish;
      end
   end

   // ---------------- stimulus ----------------------------------------------
   initial begin
      void'($urandom(32'd20240611));
      step(4);
      rst_n = 1'b1;
      step(1);

      // reset state
      rd_chk("R10 reset ctrl", 3'd0, 16'h8000);
      rd_chk("R10 reset sense", 3'd2, 16'h0000);
      rd_chk("R10 reset req", 3'd4, 16'h0000);
      chk("R11 reset line_irq", {8'd0, line_irq}, 16'h0000);
      chk("R8 reset nmi_irq", {15'd0, nmi_irq}, 16'h0000);

      // line0 low, line1 fall, line2 rise, line3 both, lines 4..7 fall
      wr(3'd2, 16'h55E4);
      rd_chk("R1 sense readback", 3'd2, 16'h55E4);

      // rising mode ignores a falling transition, latency three edges
      ext_pin[2] = 1'b0; step(5);
      rd_chk("R4 fall ignored in rise mode", 3'd4, 16'h0000);
      ext_pin[2] = 1'b1; step(2);
      rd_chk("R12 not yet after two edges", 3'd4, 16'h0000);
      step(1);
      rd_chk("R4 rise latched", 3'd4, 16'h0004);
      chk("R11 line_irq follows req", {8'd0, line_irq}, 16'h0004);

      // write-one keeps, write-zero clears
      wr(3'd4, 16'hFFFF);
      rd_chk("R6 write one keeps", 3'd4, 16'h0004);
      wr(3'd4, 16'h00FB);
      rd_chk("R6 write zero clears", 3'd4, 16'h0000);

      // falling mode
      ext_pin[1] = 1'b0; step(3);
      rd_chk("R3 fall latched", 3'd4, 16'h0002);
      wr(3'd4, 16'h0000);
      ext_pin[1] = 1'b1; step(4);
      rd_chk("R3 rise ignored in fall mode", 3'd4, 16'h0000);

      // both edges
      ext_pin[3] = 1'b0; step(3);
      rd_chk("R5 falling edge latched", 3'd4, 16'h0008);
      wr(3'd4, 16'h0000);
      rd_chk("R5 cleared", 3'd4, 16'h0000);
      ext_pin[3] = 1'b1; step(3);
      rd_chk("R5 rising edge latched", 3'd4, 16'h0008);
      wr(3'd4, 16'h0000);

      // low level persists through a clear
      ext_pin[0] = 1'b0; step(3);
      rd_chk("R2 level latched", 3'd4, 16'h0001);
      wr(3'd4, 16'h0000);
      rd_chk("R2 level survives clear", 3'd4, 16'h0001);
      step(3);
      rd_chk("R2 still set while low", 3'd4, 16'h0001);
      ext_pin[0] = 1'b1; step(4);
      wr(3'd4, 16'h0000);
      rd_chk("R2 clear after release", 3'd4, 16'h0000);

      // event and clear in the same cycle
      ext_pin[4] = 1'b0; step(2);
      wr(3'd4, 16'h0000);
      rd_chk("R7 event beats clear", 3'd4, 16'h0010);
      wr(3'd4, 16'h0000);
      rd_chk("R7 later clear works", 3'd4, 16'h0000);
      ext_pin[4] = 1'b1; step(4);

      // non-maskable pin
      nmi_pin = 1'b0; step(2);
      rd_chk("R9 level low, flag not yet", 3'd0, 16'h0000);
      step(1);
      rd_chk("R8 falling edge sets flag", 3'd0, 16'h0002);
      chk("R8 nmi_irq set", {15'd0, nmi_irq}, 16'h0001);
      wr(3'd0, 16'h0102);
      rd_chk("R8 write one keeps flag", 3'd0, 16'h0102);
      wr(3'd0, 16'h0100);
      rd_chk("R8 write zero clears flag", 3'd0, 16'h0100);
      chk("R8 nmi_irq cleared", {15'd0, nmi_irq}, 16'h0000);
      nmi_pin = 1'b1; step(3);
      rd_chk("R9 level high, R8 rising edge sets", 3'd0, 16'h8102);
      wr(3'd0, 16'hFFFF);
      rd_chk("R10 reserved ctrl bits ignored", 3'd0, 16'h8102);
      wr(3'd0, 16'h8000);
      rd_chk("R8 flag cleared, edge back to falling", 3'd0, 16'h8000);

      // reserved and unmapped
      wr(3'd4, 16'hFF00);
      rd_chk("R10 req upper bits zero", 3'd4, 16'h0000);
      wr(3'd6, 16'hFFFF);
      rd_chk("R10 unmapped reads zero", 3'd6, 16'h0000);
      rd_chk("R10 unmapped write ignored", 3'd2, 16'h55E4);
      rd_chk("R10 odd address reads zero", 3'd1, 16'h0000);

      // random phase against the model
      for (int k = 0; k < 4000; k++) begin
         logic [2:0] a;
         chk("R11 random line_irq", {8'd0, line_irq}, {8'd0, m_req});
         chk("R8 random nmi_irq", {15'd0, nmi_irq}, {15'd0, m_nmi});
         a = 3'(($urandom % 4) * 2);
         rd_chk("R1 random readback", a, model_rd(a));
         bus_wr    = ($urandom % 4) == 0;
         bus_wdata = 16'($urandom);
         for (int p = 0; p < 8; p++)
            if (($urandom % 8) == 0) ext_pin[p] = ~ext_pin[p];
         if (($urandom % 16) == 0) nmi_pin = ~nmi_pin;
         @(negedge clk);
      end
      bus_wr = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule